// File: doc/BRIEF.md
# Parallel FIFO Byte Port

This block is the device side of an 8-bit parallel byte port that sits between an external microcontroller bus and a pair of internal byte FIFOs. The host writes a byte by pulling an active-low write strobe, but only while the active-low transmit-space flag is low. It reads a byte by pulling an active-low read strobe, but only while the active-low receive-data flag is low. The block enables its data bus drivers for as long as the read strobe is low. The transmit FIFO is fed through a valid/ready push port and the receive FIFO is drained through a valid/ready pop port.

The strobes are asynchronous to the block. They pass through a chain of SYNC_STAGES flip-flops and their edges are detected in the block's own clock domain. Each flag clears on a particular strobe edge. Transmit space clears on the write falling edge. Receive data clears on the read rising edge. The host must therefore check the flag again before every byte. One byte of the receive FIFO is held ready in a staging register, so read data is already on the bus when the strobe falls. After each read, the receive-data flag stays inactive for at least RX_GAP clocks.

Top module: `pfp_port`

## Requirements
- R1: While rst_n is low, txe_n_o and rxf_n_o are high and tx_valid_o is low.
- R2: The host may hold wr_n_i low for at least two clocks with bus_i steady, at a time when no byte is pending. Then, no later than SYNC_STAGES+1 rising edges after the falling edge, tx_valid_o is high with that byte on tx_data_o. The byte stays there, unchanged, until a cycle in which tx_ready_i is high. Bytes reach the push port in the order they were written.
- R3: txe_n_o is high no later than SYNC_STAGES+1 rising clock edges after wr_n_i falls.
- R4: txe_n_o is low only when no byte is pending on the push port and tx_ready_i was high at the preceding clock edge.
- R5: bus_oe_o is high exactly while rd_n_i is low.
- R6: While rxf_n_o is low, rx_ready_o is low and bus_o holds the oldest byte taken from the pop port and not yet read. bus_o does not change while rd_n_i stays low.
- R7: A read strobe that starts while rxf_n_o is low consumes the shown byte. rxf_n_o stays low until the strobe rises, and is high no later than SYNC_STAGES+1 rising edges after rd_n_i rises.
- R8: After a byte is consumed, rxf_n_o stays high for at least RX_GAP clock cycles. It goes low again only after a new byte has been taken from the pop port.
- R9: A write falling edge that arrives while a byte is still pending on the push port is discarded.
- R10: A read strobe that starts while rxf_n_o is high consumes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 48 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| rd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| bus_i | input | 8 | Data bus value from the pad (write data) |
| bus_o | output | 8 | Read data toward the pad |
| bus_oe_o | output | 1 | Pad driver enable for bus_o |
| txe_n_o | output | 1 | Transmit-space flag, low when a byte may be written |
| rxf_n_o | output | 1 | Receive-data flag, low when a byte may be read |
| tx_valid_o | output | 1 | Push port valid toward the transmit FIFO |
| tx_data_o | output | 8 | Push port byte |
| tx_ready_i | input | 1 | Transmit FIFO has room |
| rx_valid_i | input | 1 | Receive FIFO has a byte |
| rx_data_i | input | 8 | Receive FIFO head byte |
| rx_ready_o | output | 1 | Pop request toward the receive FIFO |

## Verification
The write path and the read path run independently. A write falling edge, which captures a byte and raises txe_n_o, can land in the same clock as a read rising edge, which pops the staged byte and starts the refill gap. A push handshake can also coincide with a new write edge. The bench provokes these overlaps by running a host writer and a host reader concurrently. Each uses random strobe widths and pauses, while the push and pop sides toggle ready and valid at random. The run is judged by comparing every byte against ordered queues, in both directions, and by checking the flag timing of each transfer.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
    localparam int BYTE_W = 8;
    localparam int GAP_W  = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  strb_prev;
        logic  pend;
        logic  space_n;
        byte_t hold;
    } wr_state_t;

    typedef struct packed {
        logic             strb_prev;
        logic             full;
        logic             armed;
        logic             avail_n;
        logic [GAP_W-1:0] gap;
        byte_t            hold;
    } rd_state_t;
endpackage

// File: rtl/pfp_sync.sv
module pfp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    // reset to all ones: strobes read as inactive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/pfp_wr_ctl.sv
module pfp_wr_ctl import pfp_pkg::*; (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_n_s,
    input  byte_t wr_data_s,
    input  logic  tx_ready_i,
    output logic  txe_n_o,
    output logic  tx_valid_o,
    output byte_t tx_data_o
);
    wr_state_t st_d, st_q;
    logic      fall;

    always_comb begin
        st_d           = st_q;
        fall           = st_q.strb_prev & ~wr_n_s;
        st_d.strb_prev = wr_n_s;
        if (st_q.pend & tx_ready_i) begin
            st_d.pend = 1'b0;
        end
        // a strobe arriving while a byte is still pending is dropped
        if (fall & ~st_q.pend) begin
            st_d.pend = 1'b1;
            st_d.hold = wr_data_s;
        end
        st_d.space_n = ~(~st_d.pend & wr_n_s & tx_ready_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{strb_prev: 1'b1, pend: 1'b0, space_n: 1'b1, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign txe_n_o    = st_q.space_n;
    assign tx_valid_o = st_q.pend;
    assign tx_data_o  = st_q.hold;
endmodule

// File: rtl/pfp_rd_ctl.sv
module pfp_rd_ctl import pfp_pkg::*; #(
    parameter int RX_GAP = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_n_s,
    input  logic  rx_valid_i,
    input  byte_t rx_data_i,
    output logic  rx_ready_o,
    output logic  rxf_n_o,
    output byte_t bus_o
);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(RX_GAP);

    rd_state_t st_d, st_q;
    logic      fall, rise, pop, load;

    always_comb begin
        st_d           = st_q;
        fall           = st_q.strb_prev & ~rd_n_s;
        rise           = ~st_q.strb_prev & rd_n_s;
        st_d.strb_prev = rd_n_s;
        pop            = rise & st_q.armed;
        // a strobe counts only if the flag was shown when it began
        if (fall) begin
            st_d.armed = ~st_q.avail_n;
        end else if (rise) begin
            st_d.armed = 1'b0;
        end
        if (pop) begin
            st_d.full = 1'b0;
            st_d.gap  = GAP_LOAD;
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end
        // refill only between strobes so the bus stays steady
        load = ~st_q.full & rd_n_s & rx_valid_i;
        if (load) begin
            st_d.full = 1'b1;
            st_d.hold = rx_data_i;
        end
        st_d.avail_n = ~(st_d.full & (st_d.gap == '0) & (rd_n_s | st_d.armed));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{strb_prev: 1'b1, full: 1'b0, armed: 1'b0, avail_n: 1'b1,
                      gap: '0, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_ready_o = ~st_q.full & rd_n_s;
    assign rxf_n_o    = st_q.avail_n;
    assign bus_o      = st_q.hold;
endmodule

// File: rtl/pfp_port.sv
module pfp_port import pfp_pkg::*; #(
    parameter int SYNC_STAGES = 2,
    parameter int RX_GAP      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_n_i,
    input  logic        rd_n_i,
    input  logic [7:0]  bus_i,
    output logic [7:0]  bus_o,
    output logic        bus_oe_o,
    output logic        txe_n_o,
    output logic        rxf_n_o,
    output logic        tx_valid_o,
    output logic [7:0]  tx_data_o,
    input  logic        tx_ready_i,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_data_i,
    output logic        rx_ready_o
);
    localparam int WR_SYNC_W = BYTE_W + 1;

    logic [WR_SYNC_W-1:0] wr_s;
    logic [0:0]           rd_s;

    // strobe and data travel together so the captured byte lines up
    pfp_sync #(.W(WR_SYNC_W), .STAGES(SYNC_STAGES)) u_wr_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d ({wr_n_i, bus_i}),
        .q (wr_s)
    );

    pfp_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rd_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (rd_n_i),
        .q (rd_s)
    );

    pfp_wr_ctl u_wr (
        .clk (clk),
        .rst_n (rst_n),
        .wr_n_s (wr_s[BYTE_W]),
        .wr_data_s (wr_s[BYTE_W-1:0]),
        .tx_ready_i (tx_ready_i),
        .txe_n_o (txe_n_o),
        .tx_valid_o (tx_valid_o),
        .tx_data_o (tx_data_o)
    );

    pfp_rd_ctl #(.RX_GAP(RX_GAP)) u_rd (
        .clk (clk),
        .rst_n (rst_n),
        .rd_n_s (rd_s[0]),
        .rx_valid_i (rx_valid_i),
        .rx_data_i (rx_data_i),
        .rx_ready_o (rx_ready_o),
        .rxf_n_o (rxf_n_o),
        .bus_o (bus_o)
    );

    // pad drivers follow the raw strobe, not the synchronised copy
    assign bus_oe_o = ~rd_n_i;
endmodule

// File: rtl/pfp_port_chk.sv
module pfp_port_chk import pfp_pkg::*; #(
    parameter int SYNC_STAGES = 2,
    parameter int RX_GAP      = 8
) (
    input logic  clk,
    input logic  rst_n,
    input logic  txe_n_o,
    input logic  tx_valid_o,
    input logic  tx_ready_i,
    input byte_t tx_data_o,
    input logic  rxf_n_o,
    input logic  rx_ready_o,
    input logic  rd_n_i,
    input byte_t bus_o
);
    localparam logic [GAP_W:0] GAP_LIM    = (GAP_W+1)'(RX_GAP);
    localparam logic [3:0]     SETTLE_LIM = 4'(SYNC_STAGES + 2);

    logic           rxf_prev_q;
    logic [GAP_W:0] high_cnt_q;
    logic [3:0]     settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxf_prev_q <= 1'b1;
            high_cnt_q <= GAP_LIM;
            settle_q   <= '0;
        end else begin
            rxf_prev_q <= rxf_n_o;
            if (rxf_n_o && !rxf_prev_q) begin
                high_cnt_q <= (GAP_W+1)'(1);
            end else if (high_cnt_q < GAP_LIM) begin
                high_cnt_q <= high_cnt_q + 1'b1;
            end
            if (settle_q < SETTLE_LIM) begin
                settle_q <= settle_q + 1'b1;
            end
        end
    end

    assert_hold_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

    assert_space_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !txe_n_o |-> !tx_valid_o && $past(tx_ready_i));

    assert_held_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rxf_n_o |-> !rx_ready_o);

    assert_read_data_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == SETTLE_LIM) && !rd_n_i && $past(!rd_n_i) && $past(!rd_n_i, 2)
        |-> $stable(bus_o));

    assert_refill_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxf_n_o) |-> high_cnt_q >= GAP_LIM);
endmodule

bind pfp_port pfp_port_chk #(.SYNC_STAGES(SYNC_STAGES), .RX_GAP(RX_GAP)) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .txe_n_o (txe_n_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_data_o (tx_data_o),
    .rxf_n_o (rxf_n_o),
    .rx_ready_o (rx_ready_o),
    .rd_n_i (rd_n_i),
    .bus_o (bus_o)
);

// File: tb/sim_pfp_port.sv
module sim_pfp_port;
    localparam int CLK_PERIOD = 20;
    localparam int SYNC       = 2;
    localparam int GAP        = 8;
    localparam int N_RAND     = 60;
    localparam int WD_LIMIT   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n_i = 1'b1;
    logic       rd_n_i = 1'b1;
    logic [7:0] bus_i = 8'h00;
    logic       tx_ready_i = 1'b0;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_data_i = 8'h00;
    logic [7:0] bus_o, tx_data_o;
    logic       bus_oe_o, txe_n_o, rxf_n_o, tx_valid_o, rx_ready_o;

    int n_cmp = 0;
    int n_bad = 0;
    int tx_mode = 1;  // 0 random, 1 stalled, 2 always ready
    int rx_mode = 1;  // 0 random, 1 idle, 2 always offered
    logic [7:0] tx_exp[$];
    logic [7:0] rx_src[$];
    logic [7:0] rx_exp[$];

    pfp_port #(.SYNC_STAGES(SYNC), .RX_GAP(GAP)) u0 (
        .clk (clk), .rst_n (rst_n), .wr_n_i (wr_n_i), .rd_n_i (rd_n_i),
        .bus_i (bus_i), .bus_o (bus_o), .bus_oe_o (bus_oe_o),
        .txe_n_o (txe_n_o), .rxf_n_o (rxf_n_o),
        .tx_valid_o (tx_valid_o), .tx_data_o (tx_data_o), .tx_ready_i (tx_ready_i),
        .rx_valid_i (rx_valid_i), .rx_data_i (rx_data_i), .rx_ready_o (rx_ready_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pick_ready(input int mode, input int pct);
        if (mode == 1) return 1'b0;
        if (mode == 2) return 1'b1;
        return ($urandom % 100) < pct;
    endfunction

    // push sink and pop source, driven between edges
    always @(negedge clk) begin
        tx_ready_i = pick_ready(tx_mode, 60);
        if (rst_n && tx_valid_o && tx_ready_i) begin
            if (tx_exp.size() == 0) chk("R2 R9 unexpected pushed byte", tx_data_o, 32'h1ff);
            else chk("R2 R9 pushed byte order", tx_data_o, tx_exp.pop_front());
        end
        if (pick_ready(rx_mode, 75) && rx_src.size() > 0) begin
            rx_valid_i = 1'b1;
            rx_data_i  = rx_src[0];
        end else begin
            rx_valid_i = 1'b0;
        end
        if (rst_n && rx_valid_i && rx_ready_o) rx_exp.push_back(rx_src.pop_front());
    end

    task automatic host_write(input logic [7:0] b, input int low_cyc);
        while (txe_n_o !== 1'b0) @(negedge clk);
        bus_i  = b;
        wr_n_i = 1'b0;
        tx_exp.push_back(b);
        repeat (SYNC + 1) @(negedge clk);
        chk("R3 space flag high after write strobe", txe_n_o, 1);
        repeat (low_cyc - (SYNC + 1)) @(negedge clk);
        wr_n_i = 1'b1;
        @(negedge clk);
        bus_i = 8'($urandom);
        @(negedge clk);
    endtask

    task automatic raw_write(input logic [7:0] b);
        bus_i  = b;
        wr_n_i = 1'b0;
        repeat (4) @(negedge clk);
        wr_n_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic host_read(input bit gap_chk, input int low_cyc);
        logic [31:0] exp;
        logic [7:0]  first;
        bit          ok;
        while (rxf_n_o !== 1'b0) @(negedge clk);
        rd_n_i = 1'b0;
        #1;
        chk("R5 drivers on while read strobe low", bus_oe_o, 1);
        exp   = (rx_exp.size() > 0) ? 32'(rx_exp.pop_front()) : 32'h1ff;
        first = bus_o;
        chk("R6 read byte order", bus_o, exp);
        repeat (low_cyc) @(negedge clk);
        chk("R6 read data steady during strobe", bus_o, first);
        chk("R7 data flag held low through strobe", rxf_n_o, 0);
        rd_n_i = 1'b1;
        #1;
        chk("R5 drivers off after read strobe", bus_oe_o, 0);
        repeat (SYNC + 1) @(negedge clk);
        chk("R7 data flag high after read strobe rises", rxf_n_o, 1);
        if (gap_chk) begin
            ok = 1'b1;
            for (int k = 0; k < GAP - 1; k++) begin
                @(negedge clk);
                if (rxf_n_o !== 1'b1) ok = 1'b0;
            end
            chk("R8 data flag stays high for refill gap", ok, 1);
        end
    endtask

    task automatic raw_read();
        rd_n_i = 1'b0;
        repeat (3) @(negedge clk);
        rd_n_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R1-R10 run actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 space flag in reset", txe_n_o, 1);
        chk("R1 data flag in reset", rxf_n_o, 1);
        chk("R1 push valid in reset", tx_valid_o, 0);
        chk("R5 drivers off in reset with strobe high", bus_oe_o, 0);
        rst_n = 1'b1;

        // R4: no space shown while the push side refuses
        repeat (6) @(negedge clk);
        chk("R4 space flag high while sink stalls", txe_n_o, 1);
        tx_mode = 2;
        repeat (3) @(negedge clk);
        chk("R4 space flag low once sink ready", txe_n_o, 0);

        // R2 and R9: capture with a stalled sink, then a discarded write
        tx_mode = 1;
        repeat (2) @(negedge clk);
        tx_exp.push_back(8'hA5);
        raw_write(8'hA5);
        chk("R2 pushed valid after write", tx_valid_o, 1);
        chk("R2 pushed byte after write", tx_data_o, 32'hA5);
        raw_write(8'h3C);
        chk("R9 pending byte kept over second write", tx_data_o, 32'hA5);
        tx_mode = 2;
        repeat (3) @(negedge clk);
        chk("R2 push drained", tx_valid_o, 0);
        host_write(8'h5A, 4);
        repeat (6) @(negedge clk);
        chk("R9 no discarded byte left", tx_exp.size(), 0);

        // R10: strobe during the refill gap takes nothing
        rx_src.push_back(8'h11);
        rx_src.push_back(8'h22);
        rx_mode = 2;
        host_read(1'b0, 3);
        raw_read();
        while (rxf_n_o !== 1'b0) @(negedge clk);
        chk("R10 byte survives strobe during gap", bus_o, 32'h22);
        host_read(1'b1, 4);

        // concurrent random traffic on both paths
        for (int i = 0; i < N_RAND; i++) rx_src.push_back(8'($urandom));
        tx_mode = 0;
        rx_mode = 0;
        fork
            begin
                for (int i = 0; i < N_RAND; i++) begin
                    host_write(8'($urandom), 3 + int'($urandom % 4));
                    repeat ($urandom % 3) @(negedge clk);
                end
            end
            begin
                for (int i = 0; i < N_RAND; i++) begin
                    host_read(1'b1, 3 + int'($urandom % 3));
                    repeat ($urandom % 3) @(negedge clk);
                end
            end
        join
        tx_mode = 2;
        repeat (20) @(negedge clk);
        chk("R2 every written byte delivered", tx_exp.size(), 0);
        chk("R7 every fed byte read", rx_exp.size() + rx_src.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule